// File: doc/BRIEF.md
# Single-Step Trap Interrupt Sequencer

This block decides, at every instruction boundary of a small processor, which interrupt entry sequences must run and in which order, and then steps an entry sequencer through them. It owns the trap flag: the flag is loaded only when a flags image is restored by an interrupt return, and cleared only by an interrupt entry. Whether the completed instruction is trapped depends on the trap flag as it stood when that instruction started. The value the instruction itself leaves in the flag does not matter.

At a boundary, a software interrupt raised by the instruction, or an enabled external request, is served first. If the trap was armed, a type 1 entry follows it at once, before any handler instruction is fetched. Each entry runs five one-cycle steps: push the flags image, clear the trap and interrupt-enable flags, push the code segment, push the instruction pointer, and load the vector. A handler fetch strobe is given only after the final entry.

Top module: `step_trap_seq`

## Requirements
- R1: When the trap flag is 1 at instruction start (`insn_start`), completion of that instruction (`insn_done`) starts an entry with vector type 1. No other request is needed.
- R2: The flags image is pushed with the trap flag value held before the entry. `clr_flags` is high in the cycle after that push, and `tf_out` is 0 from the next cycle on.
- R3: If the trap flag is restored to 0 (`restore_en`, `restore_tf`=0) during a stepped instruction, the type 1 entry still runs at its completion.
- R4: A software interrupt at a trapped boundary runs its own entry first (vector `sw_type`). The type 1 entry starts in the cycle after that vector load, and only one `handler_fetch` follows.
- R5: A type 1 entry chained behind another entry pushes a flags image whose trap bit is 0.
- R6: An external request with `ext_en`=1 at a boundary is served like a software interrupt, including chaining of the trap. With `ext_en`=0 it starts no entry.
- R7: When a software interrupt and an enabled external request meet at one boundary, only the software interrupt's entry runs at that boundary.
- R8: `tf_out` changes only through a restore or an entry clear. An instruction during which the flag is restored to 1 is not trapped; the next one is.
- R9: Every entry steps in this order, one cycle per step: flags push (`push_sel`=0), clear, segment push (`push_sel`=1), pointer push (`push_sel`=2), vector load (`vec_fetch`).
- R10: `handler_fetch` is a single-cycle pulse, asserted only in the vector load of the last entry of a boundary. A boundary with no entry gives no pulse.
- R11: After reset the block is idle, `tf_out` is 0, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_start | input | 1 | Strobe at the first cycle of an instruction |
| insn_done | input | 1 | Strobe when the instruction completes (the boundary) |
| restore_en | input | 1 | Flags image restored by an interrupt return |
| restore_tf | input | 1 | Trap bit of the restored image |
| sw_req | input | 1 | Software interrupt raised by the instruction, valid with insn_done |
| sw_type | input | 8 | Vector type of the software interrupt |
| ext_req | input | 1 | External maskable request |
| ext_en | input | 1 | External interrupt enable |
| ext_type | input | 8 | Vector type of the external request |
| busy | output | 1 | An entry sequence is running |
| push_en | output | 1 | Stack push this cycle |
| push_sel | output | 2 | Pushed item: 0 flags, 1 segment, 2 pointer |
| push_tf | output | 1 | Trap bit of the pushed flags image |
| clr_flags | output | 1 | Clear-flags step |
| tf_out | output | 1 | Current trap flag |
| vec_fetch | output | 1 | Vector load step |
| vec_type | output | 8 | Vector type being served |
| handler_fetch | output | 1 | Fetch the first handler instruction |

## Verification
The assertions assume that `insn_start` and `insn_done` come only while the block is idle, each on its own cycle, with a start before every done. They also assume that `restore_en` comes only between a start and its done. The bench drives every instruction as a fixed start, optional restore, done pattern from a task. It waits for the sequencer to go idle before the next instruction, so the stimulus stays inside these assumptions. Random choices only decide which requests and flag values accompany each boundary.

// File: rtl/sts_pkg.sv
package sts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_PUSH_FLAGS = 3'd1,
    ST_CLEAR      = 3'd2,
    ST_PUSH_SEG   = 3'd3,
    ST_PUSH_PTR   = 3'd4,
    ST_LOAD_VEC   = 3'd5
  } entry_state_e;

  localparam logic [1:0] SLOT_FLAGS = 2'd0;
  localparam logic [1:0] SLOT_SEG   = 2'd1;
  localparam logic [1:0] SLOT_PTR   = 2'd2;

  // Fixed successor within one entry; the vector step is resolved by the FSM.
  function automatic entry_state_e step_after(entry_state_e s);
    case (s)
      ST_PUSH_FLAGS: return ST_CLEAR;
      ST_CLEAR:      return ST_PUSH_SEG;
      ST_PUSH_SEG:   return ST_PUSH_PTR;
      ST_PUSH_PTR:   return ST_LOAD_VEC;
      default:       return ST_IDLE;
    endcase
  endfunction

  // Stack slot code for a push step.
  function automatic logic [1:0] slot_of(entry_state_e s);
    case (s)
      ST_PUSH_SEG: return SLOT_SEG;
      ST_PUSH_PTR: return SLOT_PTR;
      default:     return SLOT_FLAGS;
    endcase
  endfunction

  // Does a boundary hold a non-trap interrupt?  Software wins over external.
  function automatic logic has_first(logic sw, logic ext, logic en);
    return sw | (ext & en);
  endfunction

endpackage

// File: rtl/sts_trap_flag.sv
module sts_trap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic insn_start,
  input  logic insn_done,
  input  logic restore_en,
  input  logic restore_val,
  input  logic clear_en,
  output logic tf_q,
  output logic trap_pend
);

  // Architectural trap flag: only restore or entry clear touch it.
  always_ff @(posedge clk) begin
    if (!rst_n)          tf_q <= 1'b0;
    else if (clear_en)   tf_q <= 1'b0;
    else if (restore_en) tf_q <= restore_val;
  end

  // Trap decision captured at instruction start, consumed at the boundary.
  always_ff @(posedge clk) begin
    if (!rst_n)          trap_pend <= 1'b0;
    else if (insn_start) trap_pend <= tf_q;
    else if (insn_done)  trap_pend <= 1'b0;
  end

endmodule

// File: rtl/sts_boundary_pick.sv
module sts_boundary_pick #(
  parameter int VEC_W     = 8,
  parameter int TRAP_TYPE = 1
) (
  input  logic             done,
  input  logic             sw_req,
  input  logic [VEC_W-1:0] sw_type,
  input  logic             ext_req,
  input  logic             ext_en,
  input  logic [VEC_W-1:0] ext_type,
  input  logic             trap_pend,
  output logic             take,
  output logic [VEC_W-1:0] first_type,
  output logic             chain
);
  import sts_pkg::*;

  localparam logic [VEC_W-1:0] TRAP_VEC = VEC_W'(TRAP_TYPE);

  logic first_w;

  always_comb begin
    first_w = has_first(sw_req, ext_req, ext_en);
    take    = done & (first_w | trap_pend);
    chain   = done & first_w & trap_pend;
    if (sw_req)         first_type = sw_type;
    else if (first_w)   first_type = ext_type;
    else                first_type = TRAP_VEC;
  end

endmodule

// File: rtl/sts_entry_fsm.sv
module sts_entry_fsm #(
  parameter int VEC_W     = 8,
  parameter int TRAP_TYPE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [VEC_W-1:0] first_type,
  input  logic             chain_in,
  output logic             busy,
  output logic             push_en,
  output logic [1:0]       push_sel,
  output logic             clr_step,
  output logic             vec_step,
  output logic [VEC_W-1:0] cur_type,
  output logic             last_vec,
  output logic             chain_q
);
  import sts_pkg::*;

  localparam logic [VEC_W-1:0] TRAP_VEC = VEC_W'(TRAP_TYPE);

  entry_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_IDLE) begin
      if (take) state_d = ST_PUSH_FLAGS;
    end else if (state_q == ST_LOAD_VEC) begin
      state_d = chain_q ? ST_PUSH_FLAGS : ST_IDLE;
    end else begin
      state_d = step_after(state_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      chain_q  <= 1'b0;
      cur_type <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && take) begin
        cur_type <= first_type;
        chain_q  <= chain_in;
      end else if (state_q == ST_LOAD_VEC && chain_q) begin
        cur_type <= TRAP_VEC;
        chain_q  <= 1'b0;
      end
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign push_en  = (state_q == ST_PUSH_FLAGS) || (state_q == ST_PUSH_SEG) ||
                    (state_q == ST_PUSH_PTR);
  assign push_sel = slot_of(state_q);
  assign clr_step = (state_q == ST_CLEAR);
  assign vec_step = (state_q == ST_LOAD_VEC);
  assign last_vec = vec_step & ~chain_q;

endmodule

// File: rtl/step_trap_seq.sv
module step_trap_seq #(
  parameter int VEC_W     = 8,
  parameter int TRAP_TYPE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_start,
  input  logic             insn_done,
  input  logic             restore_en,
  input  logic             restore_tf,
  input  logic             sw_req,
  input  logic [VEC_W-1:0] sw_type,
  input  logic             ext_req,
  input  logic             ext_en,
  input  logic [VEC_W-1:0] ext_type,
  output logic             busy,
  output logic             push_en,
  output logic [1:0]       push_sel,
  output logic             push_tf,
  output logic             clr_flags,
  output logic             tf_out,
  output logic             vec_fetch,
  output logic [VEC_W-1:0] vec_type,
  output logic             handler_fetch
);

  // Named internal events, brought out for the checker.
  logic             trap_pend_w;
  logic             take_w;
  logic             chain_pick_w;
  logic             chain_w;
  logic [VEC_W-1:0] first_type_w;
  logic             clr_w;
  logic             tf_w;
  logic             boundary_w;

  assign boundary_w = insn_done & ~busy;

  sts_trap_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_start  (insn_start),
    .insn_done   (insn_done),
    .restore_en  (restore_en),
    .restore_val (restore_tf),
    .clear_en    (clr_w),
    .tf_q        (tf_w),
    .trap_pend   (trap_pend_w)
  );

  sts_boundary_pick #(.VEC_W(VEC_W), .TRAP_TYPE(TRAP_TYPE)) u_pick (
    .done       (boundary_w),
    .sw_req     (sw_req),
    .sw_type    (sw_type),
    .ext_req    (ext_req),
    .ext_en     (ext_en),
    .ext_type   (ext_type),
    .trap_pend  (trap_pend_w),
    .take       (take_w),
    .first_type (first_type_w),
    .chain      (chain_pick_w)
  );

  sts_entry_fsm #(.VEC_W(VEC_W), .TRAP_TYPE(TRAP_TYPE)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take_w),
    .first_type (first_type_w),
    .chain_in   (chain_pick_w),
    .busy       (busy),
    .push_en    (push_en),
    .push_sel   (push_sel),
    .clr_step   (clr_w),
    .vec_step   (vec_fetch),
    .cur_type   (vec_type),
    .last_vec   (handler_fetch),
    .chain_q    (chain_w)
  );

  assign clr_flags = clr_w;
  assign tf_out    = tf_w;
  assign push_tf   = tf_w;

endmodule

// File: rtl/step_trap_seq_chk.sv
module step_trap_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_done,
  input logic       restore_en,
  input logic       restore_tf,
  input logic       busy,
  input logic       push_en,
  input logic [1:0] push_sel,
  input logic       push_tf,
  input logic       clr_flags,
  input logic       tf_out,
  input logic       vec_fetch,
  input logic       handler_fetch,
  input logic       trap_pend_w,
  input logic       chain_w
);

  AST_TRAP_STARTS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !busy && trap_pend_w) |=> (busy && push_en && push_sel == 2'd0)); // R1

  AST_CLEAR_FOLLOWS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags |-> $past(push_en && push_sel == 2'd0)); // R2

  AST_TF_LOW_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags |=> !tf_out); // R2

  AST_CHAIN_PUSHES_CLEAR_TF: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && chain_w) |=> (push_en && push_sel == 2'd0 && !push_tf)); // R5

  AST_TF_RISE_ONLY_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tf_out) |-> $past(restore_en && restore_tf)); // R8

  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    handler_fetch |=> (!handler_fetch && !busy)); // R10

  AST_FETCH_ON_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    handler_fetch |-> (vec_fetch && !chain_w)); // R10

  AST_ONE_STEP_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({push_en, clr_flags, vec_fetch}) <= 1); // R9

endmodule

bind step_trap_seq step_trap_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_done     (insn_done),
  .restore_en    (restore_en),
  .restore_tf    (restore_tf),
  .busy          (busy),
  .push_en       (push_en),
  .push_sel      (push_sel),
  .push_tf       (push_tf),
  .clr_flags     (clr_flags),
  .tf_out        (tf_out),
  .vec_fetch     (vec_fetch),
  .handler_fetch (handler_fetch),
  .trap_pend_w   (trap_pend_w),
  .chain_w       (chain_w)
);

// File: tb/step_trap_seq_test.sv
module step_trap_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       insn_start = 1'b0, insn_done = 1'b0;
  logic       restore_en = 1'b0, restore_tf = 1'b0;
  logic       sw_req = 1'b0, ext_req = 1'b0, ext_en = 1'b0;
  logic [7:0] sw_type = 8'd0, ext_type = 8'd0;
  logic       busy, push_en, push_tf, clr_flags, tf_out, vec_fetch, handler_fetch;
  logic [1:0] push_sel;
  logic [7:0] vec_type;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  step_trap_seq uut (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_done(insn_done),
    .restore_en(restore_en), .restore_tf(restore_tf), .sw_req(sw_req),
    .sw_type(sw_type), .ext_req(ext_req), .ext_en(ext_en), .ext_type(ext_type),
    .busy(busy), .push_en(push_en), .push_sel(push_sel), .push_tf(push_tf),
    .clr_flags(clr_flags), .tf_out(tf_out), .vec_fetch(vec_fetch),
    .vec_type(vec_type), .handler_fetch(handler_fetch)
  );

  // Observed trace of one boundary
  int  nv, np, nh, order_err, last_code;
  int  vt[4];
  bit  ptf[4];

  function automatic int step_code(bit pe, logic [1:0] ps, bit cl, bit vf);
    if (pe && ps == 2'd0) return 1;
    if (cl)               return 2;
    if (pe && ps == 2'd1) return 3;
    if (pe && ps == 2'd2) return 4;
    if (vf)               return 5;
    return 0;
  endfunction

  function automatic int next_code(int prev);
    return (prev == 0 || prev == 5) ? 1 : prev + 1;
  endfunction

  always @(negedge clk) begin
    int c;
    c = step_code(push_en, push_sel, clr_flags, vec_fetch);
    if (c != 0 && c != next_code(last_code)) order_err++;
    if (c == 0 && last_code >= 1 && last_code <= 4) order_err++;
    if (c == 0 && last_code == 5 && !handler_fetch && busy) order_err++;
    last_code = c;
    if (c == 1 && np < 4) begin ptf[np] = push_tf; np++; end
    if (vec_fetch && nv < 4) begin vt[nv] = int'(vec_type); nv++; end
    if (handler_fetch) nh++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  bit tf_m = 1'b0;

  // One instruction with its boundary; expectation built from the requirements.
  task automatic run_insn(bit do_rest, bit rest_v, bit sw, int swt,
                          bit ex, bit en, int ext, string req);
    bit pend, first;
    int first_t;
    int ev_n, ep_n;
    int ev[4];
    bit ep[4];
    pend = tf_m;
    if (do_rest) tf_m = rest_v;
    first   = sw || (ex && en);
    first_t = sw ? swt : ext;
    ev_n = 0; ep_n = 0;
    if (first) begin
      ev[ev_n++] = first_t; ep[ep_n++] = tf_m; tf_m = 1'b0;
      if (pend) begin ev[ev_n++] = 1; ep[ep_n++] = 1'b0; end
    end else if (pend) begin
      ev[ev_n++] = 1; ep[ep_n++] = tf_m; tf_m = 1'b0;
    end
    nv = 0; np = 0; nh = 0; order_err = 0;
    @(negedge clk) insn_start = 1'b1;
    @(negedge clk) begin
      insn_start = 1'b0;
      restore_en = do_rest; restore_tf = rest_v;
    end
    @(negedge clk) begin
      restore_en = 1'b0;
      insn_done = 1'b1; sw_req = sw; sw_type = 8'(swt);
      ext_req = ex; ext_en = en; ext_type = 8'(ext);
    end
    @(negedge clk) begin
      insn_done = 1'b0; sw_req = 1'b0; ext_req = 1'b0;
    end
    repeat (14) @(negedge clk);
    chk(nv == ev_n, req, nv, ev_n);
    for (int i = 0; i < ev_n && i < nv; i++) chk(vt[i] == ev[i], req, vt[i], ev[i]);
    chk(np == ep_n, req, np, ep_n);
    for (int i = 0; i < ep_n && i < np; i++) chk(ptf[i] == ep[i], req, int'(ptf[i]), int'(ep[i]));
    chk(nh == (ev_n > 0 ? 1 : 0), {req, " R10"}, nh, (ev_n > 0 ? 1 : 0));
    chk(order_err == 0, {req, " R9"}, order_err, 0);
    chk(tf_out == tf_m, {req, " R8"}, int'(tf_out), int'(tf_m));
    chk(!busy, req, int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !tf_out && !push_en && !clr_flags && !vec_fetch && !handler_fetch,
        "R11", int'({busy, tf_out, push_en, clr_flags, vec_fetch, handler_fetch}), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_insn(0, 0, 0, 0, 0, 0, 0, "R10 no entry");
    run_insn(1, 1, 0, 0, 0, 0, 0, "R8 set not trapped");
    run_insn(0, 0, 0, 0, 0, 0, 0, "R1 plain step R2");
    run_insn(1, 1, 0, 0, 0, 0, 0, "R8 rearm");
    run_insn(1, 0, 0, 0, 0, 0, 0, "R3 step clears tf");
    run_insn(1, 1, 0, 0, 0, 0, 0, "R8 rearm");
    run_insn(0, 0, 1, 33, 0, 0, 0, "R4 sw chain R5");
    run_insn(1, 1, 0, 0, 0, 0, 0, "R8 rearm");
    run_insn(0, 0, 0, 0, 1, 1, 8, "R6 ext chain R5");
    run_insn(0, 0, 0, 0, 1, 0, 9, "R6 ext masked");
    run_insn(1, 1, 0, 0, 0, 0, 0, "R8 rearm");
    run_insn(0, 0, 1, 200, 1, 1, 9, "R7 sw over ext");
    run_insn(0, 0, 1, 255, 0, 0, 0, "R4 sw unstepped");

    for (int k = 0; k < 300; k++) begin
      bit dr, rv, sw, ex, en;
      dr = ($urandom % 3) == 0; rv = $urandom % 2;
      sw = ($urandom % 4) == 0; ex = ($urandom % 4) == 0; en = $urandom % 2;
      run_insn(dr, rv, sw, int'($urandom % 256), ex, en, int'($urandom % 256),
               "R1 R4 R6 random");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule